// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block steps through the elements of one vector instruction, from index 0 up to the vector length minus one. For each element it decides whether that element is written, which source feeds the result, and where the result goes. It handles four instruction classes. Plain operate passes operand A through. Compare writes a one-bit equal or less-than result into the mask. Merge picks between two operands by mask bit. Index-compress writes the index of each matching element densely into a packed destination.

Each run begins with a start pulse. At that pulse the block copies the length, the class, the mask-enable flag, the match polarity, the compare kind and the 64-bit mask into its own registers. It then issues one beat per element under a valid/ready handshake. The downstream datapath reads the element index, returns the operand values for that element, and accepts the beat. After the last beat the block pulses `done`. It holds a count of the elements it wrote until the next start. The mask register is readable at all times as two 32-bit halves.

Top module: `mask_elem_seq`

## Requirements
- R1: After an accepted start, one beat is issued for each element index 0 up to min(len,64)−1, in rising order. A beat is consumed only when `out_ready` is high. While `out_ready` is low, `out_elem` and `out_dst` hold their values.
- R2: When `mask_en` is 0, every beat of an operate (op=0) or compare (op=1) run has `out_we`=1.
- R3: When `mask_en` is 1, an operate or compare beat for element i has `out_we`=1 exactly when mask bit i equals `match_pol`. Otherwise the destination is left unchanged. For operate, `out_data` is `opnd_a` and `out_dst` equals `out_elem`.
- R4: A compare writes its result into mask bit i on each written beat. `cmp_lt`=0 selects A==B and `cmp_lt`=1 selects unsigned A<B. `out_data` carries the result bit in bit 0. Mask bits that are not written keep their value.
- R5: Merge (op=2) writes every element, whatever `mask_en` is. When mask bit i equals `match_pol`, it selects `opnd_a` (`out_sel_a`=1). Otherwise it selects `opnd_b`.
- R6: Index-compress (op=3) writes only the elements whose mask bit equals `match_pol`. For the k-th such element (k counted from 0), `out_dst`=k and `out_data`=i.
- R7: When `done` is asserted, `count` equals the number of beats written in the run. For index-compress this is the number of matching mask bits among 0 up to len−1.
- R8: A length of 0 issues no beat, and `done` rises in the cycle after the start. `done` lasts one cycle.
- R9: After the start cycle, changes to `mask_in`, `op`, `mask_en`, `match_pol`, `cmp_lt` and `len` do not affect the run in progress.
- R10: `mask_lo` shows mask bits 31:0 and `mask_hi` shows bits 63:32.
- R11: After reset the block is idle. `out_valid`, `busy` and `done` are 0, and `count` and the mask are 0.
- R12: A start that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| len | input | 7 | Vector length, clamped to 64 |
| mask_in | input | 64 | Mask value loaded at start |
| mask_en | input | 1 | Masking enable for operate and compare |
| match_pol | input | 1 | Mask bit value that counts as a match |
| op | input | 2 | 0 operate, 1 compare, 2 merge, 3 index-compress |
| cmp_lt | input | 1 | Compare kind: 0 equal, 1 unsigned less-than |
| opnd_a | input | 16 | Operand A for the current element |
| opnd_b | input | 16 | Operand B for the current element |
| out_ready | input | 1 | Downstream accepts the current beat |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | Beat present |
| out_elem | output | 6 | Source element index |
| out_dst | output | 6 | Destination element index |
| out_we | output | 1 | Beat writes its destination |
| out_sel_a | output | 1 | Result taken from operand A |
| out_data | output | 16 | Result value for the beat |
| done | output | 1 | One-cycle end-of-run pulse |
| count | output | 7 | Elements written in the last run |
| mask_lo | output | 32 | Mask bits 31:0 |
| mask_hi | output | 32 | Mask bits 63:32 |

## Verification
A wrong index counter shows up on the very next accepted beat as a skipped or repeated `out_elem`. It also shows up at `done` as a beat total that differs from the length. A corrupted mask copy or write-enable decision shows up on the first affected element, through `out_we` or `out_sel_a`. For compare runs it also shows up in the final `mask_lo`/`mask_hi`. A miscounting destination counter shows up within one index-compress beat as a wrong `out_dst`, and at the end as a wrong `count`. Each run changes the control inputs right after start, so a missing snapshot register shows up within the first few beats.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
  typedef enum logic [1:0] {
    OPC_OPER  = 2'd0,
    OPC_CMP   = 2'd1,
    OPC_MERGE = 2'd2,
    OPC_IOTA  = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;
endpackage

// File: rtl/mseq_ctrl.sv
`timescale 1ns/1ps
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int NMAX = 64,
  parameter int IW   = 6,
  parameter int LW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  logic [1:0]    op_in,
  input  logic          men_in,
  input  logic          pol_in,
  input  logic          lt_in,
  input  logic          fire,
  input  logic          wr_cnt,
  output logic          load,
  output logic          busy,
  output logic          run,
  output logic          done,
  output logic [IW-1:0] idx,
  output logic [LW-1:0] len_q,
  output opc_e          op_q,
  output logic          men_q,
  output logic          pol_q,
  output logic          lt_q,
  output logic [LW-1:0] count
);
  localparam logic [LW-1:0] LEN_CAP = LW'(NMAX);

  st_e           st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_eff;
  logic          last;
  logic          idx_en, cnt_en;

  // next-state logic
  always_comb begin
    load    = start && (st_q == ST_IDLE);
    len_eff = (len_in > LEN_CAP) ? LEN_CAP : len_in;
    last    = ({1'b0, idx_q} == (len_q - 1'b1));
    st_d    = st_q;
    case (st_q)
      ST_IDLE: if (load) st_d = (len_eff == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (fire && last) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    idx_en = load || (fire && !last);
    idx_d  = load ? '0 : idx_q + 1'b1;
    cnt_en = load || (fire && wr_cnt);
    cnt_d  = load ? '0 : cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      len_q <= '0;
      op_q  <= OPC_OPER;
      men_q <= 1'b0;
      pol_q <= 1'b0;
      lt_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q <= idx_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (load) begin
        len_q <= len_eff;
        op_q  <= opc_e'(op_in);
        men_q <= men_in;
        pol_q <= pol_in;
        lt_q  <= lt_in;
      end
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign run   = (st_q == ST_RUN);
  assign done  = (st_q == ST_FIN);
  assign idx   = idx_q;
  assign count = cnt_q;
endmodule

// File: rtl/mseq_mask.sv
`timescale 1ns/1ps
module mseq_mask #(
  parameter int MW = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] mask_in,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_bit,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit,
  output logic [MW-1:0] mask_q
);
  // one register per mask bit, each with its own enable
  for (genvar b = 0; b < MW; b++) begin : g_bit
    logic en, nxt;
    always_comb begin
      en  = load || (wr_en && (wr_idx == IW'(b)));
      nxt = load ? mask_in[b] : wr_bit;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q[b] <= 1'b0;
      else if (en) mask_q[b] <= nxt;
    end
  end

  assign rd_bit = mask_q[rd_idx];
endmodule

// File: rtl/mseq_elem.sv
`timescale 1ns/1ps
module mseq_elem
  import mseq_pkg::*;
#(
  parameter int IW = 6,
  parameter int LW = 7,
  parameter int DW = 16
) (
  input  opc_e          op,
  input  logic          men,
  input  logic          pol,
  input  logic          lt,
  input  logic          mbit,
  input  logic [IW-1:0] idx,
  input  logic [LW-1:0] cnt,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          we,
  output logic          sel_a,
  output logic [IW-1:0] dst,
  output logic [DW-1:0] data,
  output logic          cres
);
  logic match;

  always_comb begin
    match = (mbit == pol);
    cres  = lt ? (a < b) : (a == b);
    we    = 1'b0;
    sel_a = 1'b1;
    dst   = idx;
    data  = a;
    case (op)
      OPC_OPER: begin
        we   = !men || match;
        data = a;
      end
      OPC_CMP: begin
        we   = !men || match;
        data = DW'(cres);
      end
      OPC_MERGE: begin
        we    = 1'b1;
        sel_a = match;
        data  = match ? a : b;
      end
      OPC_IOTA: begin
        we   = match;
        dst  = cnt[IW-1:0];
        data = DW'(idx);
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/mask_elem_seq.sv
`timescale 1ns/1ps
module mask_elem_seq
  import mseq_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [$clog2(MASK_W):0] len,
  input  logic [MASK_W-1:0]       mask_in,
  input  logic                    mask_en,
  input  logic                    match_pol,
  input  logic [1:0]              op,
  input  logic                    cmp_lt,
  input  logic [DATA_W-1:0]       opnd_a,
  input  logic [DATA_W-1:0]       opnd_b,
  input  logic                    out_ready,
  output logic                    busy,
  output logic                    out_valid,
  output logic [$clog2(MASK_W)-1:0] out_elem,
  output logic [$clog2(MASK_W)-1:0] out_dst,
  output logic                    out_we,
  output logic                    out_sel_a,
  output logic [DATA_W-1:0]       out_data,
  output logic                    done,
  output logic [$clog2(MASK_W):0] count,
  output logic [MASK_W/2-1:0]     mask_lo,
  output logic [MASK_W/2-1:0]     mask_hi
);
  localparam int IDX_W = $clog2(MASK_W);
  localparam int LEN_W = IDX_W + 1;
  localparam int HALF  = MASK_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic             load, run, fire, we, cres, mbit;
  logic [IDX_W-1:0] idx, dst;
  logic [LEN_W-1:0] len_q;
  opc_e             op_q;
  logic             men_q, pol_q, lt_q;
  logic [MASK_W-1:0] mask_q;

  assign fire = run && out_ready;

  mseq_ctrl #(.NMAX(MASK_W), .IW(IDX_W), .LW(LEN_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .start  (start),
    .len_in (len),
    .op_in  (op),
    .men_in (mask_en),
    .pol_in (match_pol),
    .lt_in  (cmp_lt),
    .fire   (fire),
    .wr_cnt (we),
    .load   (load),
    .busy   (busy),
    .run    (run),
    .done   (done),
    .idx    (idx),
    .len_q  (len_q),
    .op_q   (op_q),
    .men_q  (men_q),
    .pol_q  (pol_q),
    .lt_q   (lt_q),
    .count  (count)
  );

  mseq_mask #(.MW(MASK_W), .IW(IDX_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (load),
    .mask_in (mask_in),
    .wr_en   (fire && we && (op_q == OPC_CMP)),
    .wr_idx  (idx),
    .wr_bit  (cres),
    .rd_idx  (idx),
    .rd_bit  (mbit),
    .mask_q  (mask_q)
  );

  mseq_elem #(.IW(IDX_W), .LW(LEN_W), .DW(DATA_W)) u_elem (
    .op    (op_q),
    .men   (men_q),
    .pol   (pol_q),
    .lt    (lt_q),
    .mbit  (mbit),
    .idx   (idx),
    .cnt   (count),
    .a     (opnd_a),
    .b     (opnd_b),
    .we    (we),
    .sel_a (out_sel_a),
    .dst   (dst),
    .data  (out_data),
    .cres  (cres)
  );

  assign out_valid = run;
  assign out_elem  = idx;
  assign out_dst   = dst;
  assign out_we    = run && we;
  assign mask_lo   = mask_q[HALF-1:0];
  assign mask_hi   = mask_q[MASK_W-1:HALF];
endmodule

// File: rtl/mseq_chk.sv
`timescale 1ns/1ps
module mseq_chk
  import mseq_pkg::*;
#(
  parameter int IW = 6,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] len,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_elem,
  input logic [IW-1:0] out_dst,
  input logic          out_we,
  input logic          done,
  input logic [LW-1:0] count,
  input logic [LW-1:0] len_q,
  input opc_e          op_q,
  input logic          men_q
);
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> busy); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_elem) && $stable(out_dst))); // R1
  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready) |=> (done || (out_elem == $past(out_elem) + 1'b1))); // R1
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !men_q && (op_q == OPC_OPER || op_q == OPC_CMP)) |-> out_we); // R2
  AST_MERGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && op_q == OPC_MERGE) |-> out_we); // R5
  AST_PACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && op_q == OPC_IOTA) |-> (out_dst <= out_elem)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) done |-> (count <= len_q)); // R7
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && len == '0) |=> (done && !out_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
endmodule

bind mask_elem_seq mseq_chk #(.IW(IDX_W), .LW(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .start     (start),
  .len       (len),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_elem  (out_elem),
  .out_dst   (out_dst),
  .out_we    (out_we),
  .done      (done),
  .count     (count),
  .len_q     (len_q),
  .op_q      (op_q),
  .men_q     (men_q)
);

// File: tb/test_mask_elem_seq.sv
`timescale 1ns/1ps
module test_mask_elem_seq;
  typedef struct packed {
    logic [1:0]  op;
    logic        men;
    logic        pol;
    logic        lt;
    logic [6:0]  len;
    logic [63:0] mask;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 7'd8,   64'h0000_0000_0000_00A5},
    '{2'd0, 1'b1, 1'b1, 1'b0, 7'd16,  64'h0000_0000_0000_F0F3},
    '{2'd0, 1'b1, 1'b0, 1'b0, 7'd16,  64'h0000_0000_0000_F0F3},
    '{2'd1, 1'b0, 1'b1, 1'b0, 7'd12,  64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd1, 1'b1, 1'b1, 1'b1, 7'd20,  64'h0000_0000_000F_0F0F},
    '{2'd2, 1'b0, 1'b1, 1'b0, 7'd10,  64'h0000_0000_0000_02AA},
    '{2'd2, 1'b1, 1'b0, 1'b0, 7'd64,  64'hDEAD_BEEF_0123_4567},
    '{2'd3, 1'b0, 1'b1, 1'b0, 7'd64,  64'h8000_0001_0000_00F1},
    '{2'd3, 1'b1, 1'b0, 1'b0, 7'd40,  64'hFFFF_0000_FFFF_0F0F},
    '{2'd0, 1'b1, 1'b1, 1'b0, 7'd100, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd3, 1'b0, 1'b1, 1'b0, 7'd1,   64'h0000_0000_0000_0001},
    '{2'd1, 1'b0, 1'b1, 1'b1, 7'd0,   64'h1234_5678_9ABC_DEF0}
  };

  logic        clk, rst_n, start, mask_en, match_pol, cmp_lt, out_ready;
  logic [6:0]  len;
  logic [63:0] mask_in;
  logic [1:0]  op;
  logic [15:0] opnd_a, opnd_b;
  logic        busy, out_valid, out_we, out_sel_a, done;
  logic [5:0]  out_elem, out_dst;
  logic [15:0] out_data;
  logic [6:0]  count;
  logic [31:0] mask_lo, mask_hi;

  int checks = 0;
  int errors = 0;

  mask_elem_seq i_mask_elem_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .mask_in(mask_in),
    .mask_en(mask_en), .match_pol(match_pol), .op(op), .cmp_lt(cmp_lt),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_ready(out_ready), .busy(busy),
    .out_valid(out_valid), .out_elem(out_elem), .out_dst(out_dst),
    .out_we(out_we), .out_sel_a(out_sel_a), .out_data(out_data),
    .done(done), .count(count), .mask_lo(mask_lo), .mask_hi(mask_hi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] fa(input int i);
    return 16'(i * 5 + 3);
  endfunction
  function automatic logic [15:0] fb(input int i);
    return ((i % 4) == 1) ? fa(i) : 16'd50;
  endfunction

  // operand source indexed by the element the block presents
  always_comb begin
    opnd_a = fa(int'(out_elem));
    opnd_b = fb(int'(out_elem));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [63:0] mm;
    int L, e, ecnt, cyc;
    bit seen, m, match, ewe, esel, res;
    logic [15:0] edata;
    int edst;
    string rq;
    mm   = v.mask;
    L    = (v.len > 7'd64) ? 64 : int'(v.len);
    e    = 0;
    ecnt = 0;
    seen = 0;
    @(negedge clk);
    start = 1'b1; op = v.op; mask_en = v.men; match_pol = v.pol;
    cmp_lt = v.lt; len = v.len; mask_in = v.mask;
    @(negedge clk);
    // R9: scramble every control input once the run is under way
    start = 1'b0; mask_in = ~v.mask; mask_en = ~v.men; match_pol = ~v.pol;
    cmp_lt = ~v.lt; op = v.op + 2'd1; len = 7'd3;
    if (L == 0) chk(done == 1'b1, "R8", "done after zero-length start", done, 1);
    cyc = 0;
    while (cyc < 1000) begin
      out_ready = ((cyc % 3) != 2);
      start = poke && (cyc == 3);  // R12: start while busy
      #1;
      if (done) begin seen = 1; break; end
      if (out_valid && out_ready) begin
        m = mm[e]; match = (m == v.pol);
        esel = 1'b1; edst = e; edata = fa(e);
        case (v.op)
          2'd0: begin ewe = !v.men || match; rq = v.men ? "R3/R9" : "R2"; end
          2'd1: begin
            ewe = !v.men || match; rq = v.men ? "R3/R4" : "R2/R4";
            res = v.lt ? (fa(e) < fb(e)) : (fa(e) == fb(e));
            edata = 16'(res);
            if (ewe) mm[e] = res;
          end
          2'd2: begin ewe = 1'b1; esel = match; edata = match ? fa(e) : fb(e); rq = "R5"; end
          default: begin ewe = match; edst = ecnt; edata = 16'(e); rq = "R6"; end
        endcase
        chk(out_elem == 6'(e), "R1", "element index", out_elem, e);
        chk(out_we == ewe, rq, "write enable", out_we, ewe);
        if (ewe) begin
          chk(out_dst == 6'(edst), rq, "destination", out_dst, edst);
          chk(out_data == edata, rq, "data", out_data, edata);
        end
        if (v.op == 2'd2) chk(out_sel_a == esel, "R5", "source select", out_sel_a, esel);
        if (ewe) ecnt++;
        e++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(seen, "R1", "run reached done", seen, 1);
    chk(e == L, "R1/R12", "beat total", e, L);
    chk(count == 7'(ecnt), "R7", "written count", count, ecnt);
    chk(mask_lo == mm[31:0], "R4/R10", "mask low half", mask_lo, mm[31:0]);
    chk(mask_hi == mm[63:32], "R4/R10", "mask high half", mask_hi, mm[63:32]);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R8", "done is one cycle", done, 0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; len = '0; mask_in = '0; mask_en = 1'b0;
    match_pol = 1'b0; op = 2'd0; cmp_lt = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "valid after reset", out_valid, 0);
    chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(count == 7'd0, "R11", "count after reset", count, 0);
    chk(mask_lo == 32'd0 && mask_hi == 32'd0, "R11", "mask after reset", mask_lo, 0);
    for (int k = 0; k < NV; k++) run_vec(TBL[k], k == 6);
    // corner: index-compress with no matching bits
    run_vec('{2'd3, 1'b0, 1'b1, 1'b0, 7'd33, 64'd0}, 1'b0);
    // corner: compare touching the top mask bit only through length 64
    run_vec('{2'd1, 1'b1, 1'b0, 1'b0, 7'd64, 64'h7FFF_FFFF_FFFF_FFFE}, 1'b0);
    summary();
  end
endmodule